// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block sits at the front of an interrupt controller. It samples a set of interrupt input lines and keeps one pending-request bit for each line. Each line is either edge sensitive or level sensitive. A trigger-mode register selects the sensitivity of each line at run time, and software writes and reads that register through a one-byte port.

An edge-sensitive line holds a stored copy of its last sampled level. A request is therefore latched once for each low-to-high transition, and an input that stays high does not raise a second request. A level-sensitive line copies its input into the request bit. Acknowledge logic further down the chain sends a clear vector, and that vector removes latched requests on edge-sensitive lines.

Priority resolution and vector generation belong to the next stage. This block only provides the request vector and the current trigger-mode vector.

Top module: `irq_capture_top`

## Requirements
- R1: When a line's trigger-mode bit is 1 (level), its request bit equals that line's input as sampled at the previous clock edge. It is set while the input is high and cleared once the input is low.
- R2: When a line's trigger-mode bit is 0 (edge), its request bit becomes 1 one cycle after the input is sampled high while the stored previous level is low.
- R3: On an edge line whose input stays high, a request that has been cleared is not raised again until the input has gone low and then high again.
- R4: On an edge line, a low input leaves a latched request set. Only the stored previous level follows the input.
- R5: A write stores the written byte ANDed with the parameter TRIG_WR_MASK, where bit i of the byte controls line i. With the default mask 8'hF8, lines 0 to 2 stay edge sensitive whatever value is written.
- R6: The read port always shows the stored trigger-mode value, zero-extended to the byte width.
- R7: Reset clears the request bits, the trigger-mode register and the stored previous levels. An input that is already high when reset is released therefore counts as a rising edge on the first clock.
- R8: A 1 in the clear vector removes the request on an edge line and has no effect on a level line.
- R9: When a new edge and a clear hit the same edge line in the same cycle, the request bit ends up set.
- R10: A trigger-mode write takes effect for requests from the next cycle on. During the cycle of the write, the old mode still decides the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lvl_i | input | NUM_LINES | Interrupt input levels, synchronous to clk |
| ack_clr_i | input | NUM_LINES | Per-line clear strobes from acknowledge logic |
| cfg_wr_i | input | 1 | Write strobe for the trigger-mode byte |
| cfg_wdata_i | input | BYTE_W | Write data for the trigger-mode byte |
| cfg_rdata_o | output | BYTE_W | Read data: stored trigger-mode value |
| req_o | output | NUM_LINES | Pending-request vector |
| trig_mode_o | output | NUM_LINES | Trigger-mode vector, 1 = level |

## Verification
If a stored previous level is wrong, the error shows at req_o one cycle after the next rising input. The effect is either a missing request or a second request from an input that was held high. Both cases are provoked directly after reset release and again after a clear.

If a trigger-mode bit is wrong, it shows at cfg_rdata_o on the cycle after the write. It also shows on req_o as a request that follows the input, or that latches, when it should do the opposite. A wrong choice between set and clear priority shows on req_o in the single cycle after the two collide.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   // Next value of one request bit; a fresh edge has precedence over a clear.
   function automatic logic f_req_next(input trig_e mode, input logic din,
                                       input logic prev, input logic clr,
                                       input logic cur);
      logic nxt;
      if (mode == TRIG_LEVEL)      nxt = din;
      else if (din && !prev)       nxt = 1'b1;
      else if (clr)                nxt = 1'b0;
      else                         nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
   parameter int                   NUM_LINES    = 8,
   parameter int                   BYTE_W       = 8,
   parameter logic [NUM_LINES-1:0] TRIG_WR_MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [BYTE_W-1:0]    wdata,
   output logic [NUM_LINES-1:0] mode_q,
   output logic [BYTE_W-1:0]    rdata
);
   localparam int PAD_W = BYTE_W - NUM_LINES;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
      if (TRIG_WR_MASK[i]) begin : g_wr
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (wr_en) bit_q <= wdata[i];
         end
         assign mode_q[i] = bit_q;
      end else begin : g_fixed
         assign mode_q[i] = 1'b0;
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, mode_q};
   end else begin : g_nopad
      assign rdata = mode_q;
   end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_cap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_mode,
   input  logic din,
   input  logic clr,
   output logic req_q,
   output logic prev_q
);
   logic  req_d;
   trig_e mode;

   assign mode  = lvl_mode ? TRIG_LEVEL : TRIG_EDGE;
   assign req_d = f_req_next(mode, din, prev_q, clr, req_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         req_q  <= req_d;
         prev_q <= din;
      end
   end
endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top #(
   parameter int                   NUM_LINES    = 8,
   parameter int                   BYTE_W       = 8,
   parameter logic [NUM_LINES-1:0] TRIG_WR_MASK = 8'hF8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lvl_i,
   input  logic [NUM_LINES-1:0] ack_clr_i,
   input  logic                 cfg_wr_i,
   input  logic [BYTE_W-1:0]    cfg_wdata_i,
   output logic [BYTE_W-1:0]    cfg_rdata_o,
   output logic [NUM_LINES-1:0] req_o,
   output logic [NUM_LINES-1:0] trig_mode_o
);
   if (NUM_LINES < 1 || NUM_LINES > BYTE_W) begin : g_bad_lines
      $error("NUM_LINES must be between 1 and BYTE_W");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("configuration port is one byte wide");
   end

   logic [NUM_LINES-1:0] mode_vec;
   logic [NUM_LINES-1:0] prev_vec;

   irq_trig_cfg #(
      .NUM_LINES   (NUM_LINES),
      .BYTE_W      (BYTE_W),
      .TRIG_WR_MASK(TRIG_WR_MASK)
   ) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr_i),
      .wdata (cfg_wdata_i),
      .mode_q(mode_vec),
      .rdata (cfg_rdata_o)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      irq_line_cell cell_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_mode(mode_vec[i]),
         .din     (irq_lvl_i[i]),
         .clr     (ack_clr_i[i]),
         .req_q   (req_o[i]),
         .prev_q  (prev_vec[i])
      );
   end

   assign trig_mode_o = mode_vec;
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
   parameter int                   NUM_LINES    = 8,
   parameter int                   BYTE_W       = 8,
   parameter logic [NUM_LINES-1:0] TRIG_WR_MASK = 8'hF8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lvl_i,
   input logic [NUM_LINES-1:0] ack_clr_i,
   input logic                 cfg_wr_i,
   input logic [BYTE_W-1:0]    cfg_wdata_i,
   input logic [NUM_LINES-1:0] req_o,
   input logic [NUM_LINES-1:0] trig_mode_o,
   input logic [NUM_LINES-1:0] prev_vec
);
   // R1: level lines copy the sampled input
   assert_level_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((req_o & $past(trig_mode_o)) == ($past(irq_lvl_i) & $past(trig_mode_o))));

   // R2 and R9: a rising edge on an edge line always leaves the request set
   assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(irq_lvl_i) & ~$past(prev_vec) & ~$past(trig_mode_o)) & ~req_o) == '0));

   // R3: a held-high edge input does not raise a cleared request again
   assert_no_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(irq_lvl_i) & $past(prev_vec) & ~$past(trig_mode_o) & ~$past(req_o)) & req_o) == '0));

   // R4: without a clear, a latched edge request stays set
   assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(req_o) & ~$past(ack_clr_i) & ~$past(trig_mode_o)) & ~req_o) == '0));

   // R8: a clear without a concurrent edge removes an edge request
   assert_clear_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(ack_clr_i) & ~$past(trig_mode_o) &
                  ~($past(irq_lvl_i) & ~$past(prev_vec))) & req_o) == '0));

   // R5: a write stores the masked byte
   assert_masked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_i |=> (trig_mode_o == ($past(cfg_wdata_i[NUM_LINES-1:0]) & TRIG_WR_MASK)));

   // R10: the mode changes only through a write
   assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_i |=> $stable(trig_mode_o));
endmodule

bind irq_capture_top irq_capture_chk #(
   .NUM_LINES   (NUM_LINES),
   .BYTE_W      (BYTE_W),
   .TRIG_WR_MASK(TRIG_WR_MASK)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_lvl_i  (irq_lvl_i),
   .ack_clr_i  (ack_clr_i),
   .cfg_wr_i   (cfg_wr_i),
   .cfg_wdata_i(cfg_wdata_i),
   .req_o      (req_o),
   .trig_mode_o(trig_mode_o),
   .prev_vec   (prev_vec)
);

// File: tb/irq_capture_top_tb_top.sv
`timescale 1ns/1ps
module irq_capture_top_tb_top;
   localparam int       N    = 8;
   localparam logic [7:0] MASK = 8'hF8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0, clr = '0, wdata = '0, rdata, req, trig;
   logic       wr = 1'b0;

   always #2.5 clk = ~clk;

   irq_capture_top #(.NUM_LINES(N), .BYTE_W(8), .TRIG_WR_MASK(MASK)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq), .ack_clr_i(clr),
      .cfg_wr_i(wr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
      .req_o(req), .trig_mode_o(trig)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic [7:0] q_req[$];
   logic [7:0] q_trig[$];
   string      q_tag[$];

   // reference state
   logic [7:0] m_req = '0, m_prev = '0, m_trig = '0;

   task automatic step(input logic [7:0] i_irq, input logic [7:0] i_clr,
                       input logic i_wr, input logic [7:0] i_wd, input string tag);
      @(negedge clk);
      irq = i_irq; clr = i_clr; wr = i_wr; wdata = i_wd;
      for (int b = 0; b < N; b++) begin
         if (m_trig[b])                      m_req[b] = i_irq[b];
         else if (i_irq[b] && !m_prev[b])    m_req[b] = 1'b1;
         else if (i_clr[b])                  m_req[b] = 1'b0;
      end
      m_prev = i_irq;
      if (i_wr) m_trig = i_wd & MASK;
      q_req.push_back(m_req);
      q_trig.push_back(m_trig);
      q_tag.push_back(tag);
   endtask

   // monitor: compares one expected item per clock
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_tag.size() != 0) begin
            logic [7:0] er, et;
            string tg;
            er = q_req.pop_front();
            et = q_trig.pop_front();
            tg = q_tag.pop_front();
            tests++;
            if (req !== er || trig !== et || rdata !== et) begin
               fails++;
               $display("FAIL %s: req=%h trig=%h rd=%h expected req=%h trig=%h rd=%h",
                        tg, req, trig, rdata, er, et, et);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      irq = 8'h08;              // held high through reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      tests++;                  // R7: reset state
      if (req !== 8'h00 || trig !== 8'h00 || rdata !== 8'h00) begin
         fails++;
         $display("FAIL R7: req=%h trig=%h rd=%h expected 00 00 00", req, trig, rdata);
      end
      rst_n = 1'b1;
      step(8'h08, 8'h00, 0, 8'h00, "R7 high at release is an edge");
      step(8'h08, 8'h08, 0, 8'h00, "R8 clear edge request");
      step(8'h08, 8'h00, 0, 8'h00, "R3 held high no new request");
      step(8'h00, 8'h00, 0, 8'h00, "R3 low");
      step(8'h01, 8'h00, 0, 8'h00, "R2 rising edge line0");
      step(8'h00, 8'h00, 0, 8'h00, "R4 falling keeps request");
      step(8'h11, 8'h00, 1, 8'hFF, "R10 write cycle uses old mode; R5 mask");
      step(8'h10, 8'h00, 0, 8'h00, "R1 level high; R6 readback");
      step(8'h00, 8'h00, 0, 8'h00, "R1 level low clears");
      step(8'h20, 8'h00, 0, 8'h00, "R1 level sets");
      step(8'h20, 8'h21, 0, 8'h00, "R8 clear ignored on level line");
      step(8'h00, 8'h00, 1, 8'h5A, "R5 partial write");
      step(8'h00, 8'h00, 1, 8'h00, "R5 back to edge");
      step(8'h40, 8'h40, 0, 8'h00, "R9 edge beats clear");
      step(8'h00, 8'hFF, 0, 8'h00, "R8 clear all edge");
      lf = 8'hA5;
      for (int k = 0; k < 60; k++) begin
         logic fb;
         fb = lf[7] ^ lf[5] ^ lf[4] ^ lf[3];
         lf = {lf[6:0], fb};
         step(lf, {lf[3:0], lf[7:4]} & 8'h3C, (k % 13) == 5, lf ^ 8'h96,
              "R2 mixed pattern");
      end
      while (q_tag.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule